// File: doc/BRIEF.md
# Token-Chained FIFO Cascade

This block builds one deep first-in/first-out buffer out of several identical storage slices. Each slice owns a small ring of words with its own write and read pointers. Instead of decoding one global address, the cascade circulates two tokens around a ring of slices: a write token that marks the slice accepting the next word, and a read token that marks the slice supplying the next word. When a slice stores into, or delivers from, its highest physical location, it fires a one-cycle handoff pulse. That pulse moves the matching token to the next slice in the ring, and the last slice wraps back to the first.

Outside the block there is one shared write strobe, one shared read strobe, a data input, a data output, and composite full and empty flags. Internally the first slice is strapped as the first-load slice and starts with both tokens. With a single slice the block degenerates to a plain standalone buffer that never hands off its tokens. Words move on the rising clock edge, and the reset is asynchronous and active low.

Top module: `chain_fifo`

## Requirements
- R1: While reset is held and on the first cycle after it, `emptyAll` is 1, `fullAll` is 0 and `rdData` is all zeros.
- R2: Words leave in the order they were accepted, across slice boundaries, and the total capacity is `NUM_SLICES*SLICE_DEPTH` words.
- R3: Exactly one slice holds the write token and exactly one holds the read token at all times. After reset both tokens sit in the first-load slice (index 0).
- R4: An accepted write to a slice's last location passes the write token to the next slice (index+1, wrapping to 0), and the pass takes effect on the next clock. Back-to-back writes therefore continue in the next slice with no lost cycle. Reads hand off the read token the same way.
- R5: `fullAll` is 1 exactly when every slice is full, which is when the buffer holds `NUM_SLICES*SLICE_DEPTH` words. `emptyAll` is 1 exactly when every slice is empty. The two flags are never 1 together.
- R6: A write strobe while `fullAll` is 1 stores nothing. The refused word never appears at the output.
- R7: A read strobe while `emptyAll` is 1 consumes nothing and leaves `rdData` unchanged.
- R8: An accepted read presents its word on `rdData` in the cycle after the strobe edge. The word is held until the next accepted read.
- R9: Read and write strobes in the same cycle are both honoured unless the buffer is at a limit. When full, only the read is taken. When empty, only the write is taken.
- R10: With `NUM_SLICES` = 1 the single slice keeps both tokens permanently and behaves as a standalone buffer of `SLICE_DEPTH` words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Shared write strobe, one word per cycle |
| wrData | input | DATA_W | Word to store |
| rdEn | input | 1 | Shared read strobe, one word per cycle |
| rdData | output | DATA_W | Last word read, registered |
| fullAll | output | 1 | Composite full: every slice full |
| emptyAll | output | 1 | Composite empty: every slice empty |

## Verification
On every cycle, the embedded properties check the following:
- each token is held by exactly one slice, and a handoff pulse lands the token in the ring neighbour one clock later;
- no slice is written while the composite full flag is up;
- the output word stays frozen while the composite empty flag is up.

Ordering across slice boundaries, the exact capacity at which full rises, and the fate of refused words can only be shown by the bench. It drives directed fill and drain runs, strobes at both limits and a long pseudo-random strobe sweep, and compares each cycle against a queue model of the chained and single-slice configurations.

// File: rtl/chain_pkg.sv
package chain_pkg;
  // Per-slice strobes issued by the slice control to its storage.
  typedef struct packed {
    logic wr;
    logic rd;
  } slice_stb_t;
endpackage

// File: rtl/slice_ctrl.sv
module slice_ctrl
  import chain_pkg::*;
#(
  parameter int DEPTH   = 4,
  parameter bit CHAINED = 1'b1
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic                                  firstLoad,
  input  logic                                  wrEn,
  input  logic                                  rdEn,
  input  logic                                  xiWr,
  input  logic                                  xiRd,
  output slice_stb_t                            stb,
  output logic [((DEPTH > 1) ? $clog2(DEPTH) : 1)-1:0] wrAddr,
  output logic [((DEPTH > 1) ? $clog2(DEPTH) : 1)-1:0] rdAddr,
  output logic                                  xoWr,
  output logic                                  xoRd,
  output logic                                  wrTok,
  output logic                                  rdTok,
  output logic                                  isFull,
  output logic                                  isEmpty
);
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int LAST = DEPTH - 1;

  logic [AW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] cnt;
  logic          wrLast, rdLast;

  assign isFull  = (cnt == CW'(DEPTH));
  assign isEmpty = (cnt == '0);
  assign wrLast  = (wrPtr == AW'(LAST));
  assign rdLast  = (rdPtr == AW'(LAST));

  assign stb.wr = wrEn & wrTok & ~isFull;
  assign stb.rd = rdEn & rdTok & ~isEmpty;
  assign wrAddr = wrPtr;
  assign rdAddr = rdPtr;

  // Handoff pulses exist only inside a ring of several slices.
  generate
    if (CHAINED) begin : g_ring
      assign xoWr = stb.wr & wrLast;
      assign xoRd = stb.rd & rdLast;
    end else begin : g_alone
      assign xoWr = 1'b0;
      assign xoRd = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      cnt   <= '0;
      wrTok <= firstLoad;
      rdTok <= firstLoad;
    end else begin
      if (stb.wr) wrPtr <= wrLast ? '0 : wrPtr + AW'(1);
      if (stb.rd) rdPtr <= rdLast ? '0 : rdPtr + AW'(1);
      case ({stb.wr, stb.rd})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
      wrTok <= (wrTok & ~xoWr) | xiWr;
      rdTok <= (rdTok & ~xoRd) | xiRd;
    end
  end

  AST_SLICE_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    isFull && !stb.rd |=> isFull); // R2
endmodule

// File: rtl/slice_mem.sv
module slice_mem
  import chain_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 9,
  parameter int AW     = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  slice_stb_t        stb,
  input  logic [AW-1:0]     wrAddr,
  input  logic [AW-1:0]     rdAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdWord
);
  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (stb.wr) store[wrAddr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       rdWord <= '0;
    else if (stb.rd) rdWord <= store[rdAddr];
  end
endmodule

// File: rtl/chain_fifo.sv
module chain_fifo
  import chain_pkg::*;
#(
  parameter int NUM_SLICES  = 3,
  parameter int SLICE_DEPTH = 4,
  parameter int DATA_W      = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              fullAll,
  output logic              emptyAll
);
  localparam int AW      = (SLICE_DEPTH > 1) ? $clog2(SLICE_DEPTH) : 1;
  localparam bit CHAINED = (NUM_SLICES > 1);

  logic [NUM_SLICES-1:0] xoWr, xoRd, wrTok, rdTok, sFull, sEmpty, wrHit, rdHit;
  logic [NUM_SLICES-1:0] srcSel;
  logic [DATA_W-1:0]     sWord [NUM_SLICES];

  generate
    for (genvar g = 0; g < NUM_SLICES; g++) begin : g_slice
      localparam int PRV = (g + NUM_SLICES - 1) % NUM_SLICES;
      localparam int NXT = (g + 1) % NUM_SLICES;
      slice_stb_t    stbG;
      logic [AW-1:0] wrAddrG, rdAddrG;

      slice_ctrl #(.DEPTH(SLICE_DEPTH), .CHAINED(CHAINED)) u_ctrl (
        .clk      (clk),
        .rstN     (rstN),
        .firstLoad(g == 0),
        .wrEn     (wrEn),
        .rdEn     (rdEn),
        .xiWr     (xoWr[PRV]),
        .xiRd     (xoRd[PRV]),
        .stb      (stbG),
        .wrAddr   (wrAddrG),
        .rdAddr   (rdAddrG),
        .xoWr     (xoWr[g]),
        .xoRd     (xoRd[g]),
        .wrTok    (wrTok[g]),
        .rdTok    (rdTok[g]),
        .isFull   (sFull[g]),
        .isEmpty  (sEmpty[g])
      );

      slice_mem #(.DEPTH(SLICE_DEPTH), .DATA_W(DATA_W), .AW(AW)) u_mem (
        .clk   (clk),
        .rstN  (rstN),
        .stb   (stbG),
        .wrAddr(wrAddrG),
        .rdAddr(rdAddrG),
        .wrData(wrData),
        .rdWord(sWord[g])
      );

      assign wrHit[g] = stbG.wr;
      assign rdHit[g] = stbG.rd;

      if (CHAINED) begin : g_handoff
        AST_WR_HANDOFF: assert property (@(posedge clk) disable iff (!rstN)
          xoWr[g] |=> wrTok[NXT] && !wrTok[g]); // R4
        AST_RD_HANDOFF: assert property (@(posedge clk) disable iff (!rstN)
          xoRd[g] |=> rdTok[NXT] && !rdTok[g]); // R4
      end
    end
  endgenerate

  // Remember which slice served the latest read; hold it otherwise.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        srcSel <= '0;
    else if (|rdHit)  srcSel <= rdHit;
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_SLICES; i++)
      if (srcSel[i]) rdData = rdData | sWord[i];
  end

  assign fullAll  = &sFull;
  assign emptyAll = &sEmpty;

  AST_ONE_WR_TOKEN: assert property (@(posedge clk) disable iff (!rstN)
    $onehot(wrTok)); // R3
  AST_ONE_RD_TOKEN: assert property (@(posedge clk) disable iff (!rstN)
    $onehot(rdTok)); // R3
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(fullAll && emptyAll)); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    fullAll |-> !(|wrHit)); // R6
  AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    emptyAll |=> $stable(rdData)); // R7

  generate
    if (!CHAINED) begin : g_solo_chk
      AST_SOLO_TOKENS: assert property (@(posedge clk) disable iff (!rstN)
        wrTok[0] && rdTok[0]); // R10
    end
  endgenerate
endmodule

// File: tb/chain_fifo_bench.sv
module chain_fifo_bench;
  localparam int N   = 3;
  localparam int D   = 4;
  localparam int DW  = 9;
  localparam int CAP = N * D;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rstN, wrEn, rdEn;
  logic [DW-1:0] wrData;
  logic [DW-1:0] rdData, soloData;
  logic          fullAll, emptyAll, soloFull, soloEmpty;

  chain_fifo #(.NUM_SLICES(N), .SLICE_DEPTH(D), .DATA_W(DW)) u_chain_fifo (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
    .rdData(rdData), .fullAll(fullAll), .emptyAll(emptyAll));

  chain_fifo #(.NUM_SLICES(1), .SLICE_DEPTH(D), .DATA_W(DW)) u_chain_fifo_solo (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
    .rdData(soloData), .fullAll(soloFull), .emptyAll(soloEmpty));

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [DW-1:0] q0[$];
  logic [DW-1:0] q1[$];
  logic [DW-1:0] last0, last1, wdat;
  logic [15:0]   lfsr;

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    check(tag,   "rdData",   int'(rdData),   int'(last0));
    check("R5",  "fullAll",  int'(fullAll),  int'(q0.size() == CAP));
    check("R5",  "emptyAll", int'(emptyAll), int'(q0.size() == 0));
    check("R10", "solo rdData", int'(soloData),  int'(last1));
    check("R10", "solo full",   int'(soloFull),  int'(q1.size() == D));
    check("R10", "solo empty",  int'(soloEmpty), int'(q1.size() == 0));
  endtask

  // One cycle: check state from the previous edges, drive, advance models.
  task automatic step(input logic we, input logic re, input string tag);
    bit aw0, ar0, aw1, ar1;
    @(negedge clk);
    compare(tag);
    wrEn = we; rdEn = re; wrData = wdat;
    aw0 = we && (q0.size() < CAP); ar0 = re && (q0.size() > 0);
    aw1 = we && (q1.size() < D);   ar1 = re && (q1.size() > 0);
    if (ar0) last0 = q0.pop_front();
    if (aw0) q0.push_back(wdat);
    if (ar1) last1 = q1.pop_front();
    if (aw1) q1.push_back(wdat);
    wdat = wdat + 1'b1;
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    rstN = 1'b0; wrEn = 1'b0; rdEn = 1'b0; wrData = '0;
    wdat = 9'd1; last0 = '0; last1 = '0; lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    check("R1", "emptyAll in reset", int'(emptyAll), 1);
    check("R1", "fullAll in reset",  int'(fullAll),  0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "emptyAll", int'(emptyAll), 1);
    check("R1", "fullAll",  int'(fullAll),  0);
    check("R1", "rdData",   int'(rdData),   0);

    // R4: back-to-back writes cross every slice boundary
    for (int i = 0; i < CAP; i++) step(1'b1, 1'b0, "R4");
    step(1'b0, 1'b0, "R5");
    check("R5",  "full after N*D writes", int'(fullAll), 1);
    check("R10", "solo full after D writes", int'(soloFull), 1);

    // R6: a write offered while full is dropped
    wdat = 9'h1FF;
    step(1'b1, 1'b0, "R6");
    step(1'b0, 1'b0, "R6");
    check("R6", "still full", int'(fullAll), 1);

    // R2: drain back-to-back, order checked each cycle
    for (int i = 0; i < CAP; i++) step(1'b0, 1'b1, "R2");
    step(1'b0, 1'b0, "R2");
    check("R5", "empty after final read", int'(emptyAll), 1);
    check("R2", "last word out", int'(rdData), CAP);

    // R7: reads on empty leave the output alone
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, "R7");
    step(1'b0, 1'b0, "R7");
    check("R7", "rdData held", int'(rdData), CAP);

    // R9: simultaneous strobes at both limits
    step(1'b1, 1'b1, "R9");
    step(1'b0, 1'b0, "R9");
    check("R9", "write taken at empty", int'(emptyAll), 0);
    for (int i = 0; i < CAP - 1; i++) step(1'b1, 1'b0, "R9");
    step(1'b1, 1'b1, "R9");
    step(1'b0, 1'b0, "R9");
    check("R9", "only read taken at full", int'(fullAll), 0);

    // R8: output holds across idle cycles after a read
    step(1'b0, 1'b1, "R8");
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, "R8");

    // R3: pseudo-random strobes; ordering relies on single token holders
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0], lfsr[3], "R3");
    end

    for (int i = 0; i < CAP + 2; i++) step(1'b0, 1'b1, "R2");
    step(1'b0, 1'b0, "R2");
    check("R5", "empty after final drain", int'(emptyAll), 1);

    done = 1'b1;
    finishRun();
  end
endmodule